// File: doc/BRIEF.md
# Downstream Port Power and Status LED Controller

This block manages the supply switches and the two-colour status lamps of up to four downstream ports of a hub. For every port it drives one switch-enable pin and watches one active-low over-current pin. A hub core around it supplies the port state, the power requests, the suspend state and the strap configuration. The block filters each over-current pin, turns off the affected power, and keeps a sticky change flag that the hub core clears.

Two power arrangements exist. In individual mode every port has its own enable pin and over-current pin. In ganged mode only the first port's pins are used. That pair feeds every port: the enable turns on when any valid port asks for power, and a fault on it flags every valid port. A strap sets whether the enable pins are active high or active low.

The lamps run in one of two modes. In automatic mode they follow the port state. In manual mode each port has a two-bit selector, and amber blinks. During global suspend every lamp is dark. Ports at or above the configured port count stay unpowered and dark.

Top module: `dpc_port_ctl`

## Requirements
- R1: In individual mode, a valid port i (i < port_count) whose power request is high and whose change flag is clear has its power on one cycle after the request. Its power is off otherwise.
- R2: A port whose power is on drives its enable pin to the value of en_active_high, and a port whose power is off drives the inverse. So 1 means active-high and 0 means active-low.
- R3: In ganged mode only port 0's enable pin can turn on. It is on when any valid port requests power and has a clear flag. The other enable pins stay at the off level, and over-current pins 1..N-1 are ignored.
- R4: An over-current pin is treated as asserted when it is low. It passes through a two-flop synchroniser. It raises an event only after DEB consecutive synchronised low samples, so a low pulse lasting fewer than DEB clock edges raises nothing.
- R5: An event sets the port's change flag and removes that port's power at the same edge. In ganged mode an event on pin 0 sets the flag of every valid port. A flag stays set until its oc_clr bit is pulsed, and a new event wins over a clear in the same cycle. Power returns one cycle after the clear if it is still requested.
- R6: In automatic mode (led_manual=0) a valid port's lamp is amber when port_error or its change flag is set. Otherwise it is green when port_enabled is set, and dark otherwise. Green and amber are never lit together.
- R7: In manual mode each port's lamp follows its two-bit field led_sel[2i+1:2i]. 0 means dark, 1 means steady green, 2 means amber blinking with a phase that toggles every BLINK_HALF cycles, and 3 means dark.
- R8: While suspend is high all lamp outputs are 0, from the cycle after it is sampled.
- R9: A port with index at or above port_count has its power off, its change flag clear and its lamps dark, whatever its inputs are.
- R10: During reset all power is off, all flags are clear and all lamps are dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| gang_mode | input | 1 | 1 selects ganged power, 0 individual |
| en_active_high | input | 1 | enable pin polarity: 1 active-high, 0 active-low |
| port_count | input | 3 | number of valid ports, 0..N |
| suspend | input | 1 | hub globally suspended |
| led_manual | input | 1 | 1 selects manual lamp mode |
| pwr_req | input | 4 | per-port power request |
| port_enabled | input | 4 | per-port enabled state |
| port_error | input | 4 | per-port error state |
| led_sel | input | 8 | per-port manual lamp selector, two bits each |
| oc_n | input | 4 | per-port over-current pins, active low |
| oc_clr | input | 4 | per-port change-flag clear pulse |
| pwr_en_pin | output | 4 | per-port switch enable pins |
| oc_change | output | 4 | per-port sticky over-current change flags |
| led_green | output | 4 | per-port green lamp |
| led_amber | output | 4 | per-port amber lamp |

## Verification
Random configurations mix ganged and individual power, both polarities, port counts from 0 to 4, and random request, state, error and selector vectors. Comparing these against a bench model separates the port-0 OR fold of ganged mode from per-port enables, and it exposes a polarity inversion or a wrong range cut. Directed over-current pulses one edge shorter than the filter length and a few edges longer separate proper debouncing from a raw pass-through. A fault on a higher pin in ganged mode separates masking from per-port tripping. A fault on pin 0 in ganged mode confirms that every valid flag is set. A long manual amber window must show both blink phases while green stays dark.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    SEL_OFF   = 2'd0,
    SEL_GREEN = 2'd1,
    SEL_AMBER = 2'd2,
    SEL_DARK  = 2'd3
  } led_sel_e;
endpackage

// File: rtl/dpc_oc_filter.sv
module dpc_oc_filter #(
  parameter int N   = 4,
  parameter int DEB = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] oc_n,
  input  logic [N-1:0] mask,
  output logic [N-1:0] ev
);
  localparam int CW = $clog2(DEB + 1);
  localparam logic [CW-1:0] DEB_C  = CW'(DEB);
  localparam logic [CW-1:0] LAST_C = CW'(DEB - 1);

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic          s1_q, s2_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hot;

    assign hot = ~s2_q & mask[i];

    always_comb begin
      if (!hot)              cnt_d = '0;
      else if (cnt_q == DEB_C) cnt_d = cnt_q;
      else                   cnt_d = cnt_q + 1'b1;
    end

    assign ev[i] = hot && (cnt_q == LAST_C);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q  <= 1'b1;
        s2_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        s1_q  <= oc_n[i];
        s2_q  <= s1_q;
        cnt_q <= cnt_d;
      end
    end

    // R4: the run counter saturates at the filter length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DEB_C);
    // R4: one event per sustained assertion
    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> !ev[i]);
  end
endmodule

// File: rtl/dpc_blink.sv
module dpc_blink #(
  parameter int HALF = 24000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d, wrap;

  assign wrap = (cnt_q == WRAP);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    ph_d  = wrap ? ~ph_q : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;

  // R7: the blink phase only moves at the end of a half period
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ph_q));
endmodule

// File: rtl/dpc_led_ctl.sv
module dpc_led_ctl
  import dpc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           manual,
  input  logic           suspend,
  input  logic           phase,
  input  logic [N-1:0]   in_range,
  input  logic [N-1:0]   enabled,
  input  logic [N-1:0]   error,
  input  logic [N-1:0]   flag,
  input  logic [2*N-1:0] sel,
  output logic [N-1:0]   green,
  output logic [N-1:0]   amber
);
  logic [N-1:0] g_d, a_d, g_q, a_q;

  for (genvar i = 0; i < N; i++) begin : g_lamp
    led_sel_e s;
    assign s = led_sel_e'(sel[2*i +: 2]);

    always_comb begin
      g_d[i] = 1'b0;
      a_d[i] = 1'b0;
      if (!suspend && in_range[i]) begin
        if (manual) begin
          g_d[i] = (s == SEL_GREEN);
          a_d[i] = (s == SEL_AMBER) && phase;
        end else if (error[i] || flag[i]) begin
          a_d[i] = 1'b1;
        end else begin
          g_d[i] = enabled[i];
        end
      end
    end

    // R6: never both colours on one port
    p_colour_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_q[i] && a_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q <= '0;
      a_q <= '0;
    end else begin
      g_q <= g_d;
      a_q <= a_d;
    end
  end

  assign green = g_q;
  assign amber = a_q;

  // R8: suspend darkens every lamp
  p_suspend_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (green == '0) && (amber == '0));
endmodule

// File: rtl/dpc_port_ctl.sv
module dpc_port_ctl #(
  parameter int N          = 4,
  parameter int DEB        = 16,
  parameter int BLINK_HALF = 24000000,
  localparam int CW        = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gang_mode,
  input  logic           en_active_high,
  input  logic [CW-1:0]  port_count,
  input  logic           suspend,
  input  logic           led_manual,
  input  logic [N-1:0]   pwr_req,
  input  logic [N-1:0]   port_enabled,
  input  logic [N-1:0]   port_error,
  input  logic [2*N-1:0] led_sel,
  input  logic [N-1:0]   oc_n,
  input  logic [N-1:0]   oc_clr,
  output logic [N-1:0]   pwr_en_pin,
  output logic [N-1:0]   oc_change,
  output logic [N-1:0]   led_green,
  output logic [N-1:0]   led_amber
);
  logic [N-1:0] in_range, mask, oc_ev, ev_sel;
  logic [N-1:0] flag_q, flag_d, on_q, on_d, req_ok;
  logic         phase;

  for (genvar i = 0; i < N; i++) begin : g_cfg
    assign in_range[i] = (port_count > CW'(i));
    if (i == 0) begin : g_first
      assign mask[i]   = 1'b1;
      assign ev_sel[i] = oc_ev[0];
    end else begin : g_rest
      assign mask[i]   = ~gang_mode;
      assign ev_sel[i] = gang_mode ? oc_ev[0] : oc_ev[i];
    end
  end

  dpc_oc_filter #(.N(N), .DEB(DEB)) u_filter (
    .clk  (clk),
    .rst_n(rst_n),
    .oc_n (oc_n),
    .mask (mask),
    .ev   (oc_ev)
  );

  dpc_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk  (clk),
    .rst_n(rst_n),
    .phase(phase)
  );

  always_comb begin
    flag_d = in_range & ((flag_q & ~oc_clr) | ev_sel);
    req_ok = pwr_req & in_range & ~flag_d;
    on_d   = '0;
    if (gang_mode) on_d[0] = |req_ok;
    else           on_d    = req_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      on_q   <= '0;
    end else begin
      flag_q <= flag_d;
      on_q   <= on_d;
    end
  end

  assign pwr_en_pin = en_active_high ? on_q : ~on_q;
  assign oc_change  = flag_q;

  dpc_led_ctl #(.N(N)) u_led (
    .clk     (clk),
    .rst_n   (rst_n),
    .manual  (led_manual),
    .suspend (suspend),
    .phase   (phase),
    .in_range(in_range),
    .enabled (port_enabled),
    .error   (port_error),
    .flag    (flag_q),
    .sel     (led_sel),
    .green   (led_green),
    .amber   (led_amber)
  );

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: a filtered fault cuts the port and raises its flag
    p_fault_cuts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gang_mode && in_range[i] && oc_ev[i]) |=> (!on_q[i] && oc_change[i]));
    // R5: the flag holds until cleared
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_change[i] && !oc_clr[i] && in_range[i]) |=> oc_change[i]);
    // R9: ports beyond the count stay off and unflagged
    p_out_of_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_range[i] |=> (!on_q[i] && !oc_change[i] && !led_green[i] && !led_amber[i]));
  end

  if (N > 1) begin : g_gang_chk
    // R3: ganged mode drives only the first enable
    p_gang_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gang_mode |=> (on_q[N-1:1] == '0));
  end
endmodule

// File: tb/dpc_port_ctl_test.sv
module dpc_port_ctl_test;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int DEB   = 4;
  localparam int HALF  = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         gang_mode, en_active_high, suspend, led_manual;
  logic [2:0]   port_count;
  logic [N-1:0] pwr_req, port_enabled, port_error, oc_n, oc_clr;
  logic [2*N-1:0] led_sel;
  logic [N-1:0] pwr_en_pin, oc_change, led_green, led_amber;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  dpc_port_ctl #(.N(N), .DEB(DEB), .BLINK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .gang_mode(gang_mode),
    .en_active_high(en_active_high), .port_count(port_count),
    .suspend(suspend), .led_manual(led_manual), .pwr_req(pwr_req),
    .port_enabled(port_enabled), .port_error(port_error),
    .led_sel(led_sel), .oc_n(oc_n), .oc_clr(oc_clr),
    .pwr_en_pin(pwr_en_pin), .oc_change(oc_change),
    .led_green(led_green), .led_amber(led_amber)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pins(logic g, logic pol, logic [2:0] cnt,
                                            logic [N-1:0] req, logic [N-1:0] flg);
    logic [N-1:0] ok, on;
    for (int i = 0; i < N; i++) ok[i] = req[i] && (i < cnt) && !flg[i];
    on = '0;
    if (g) on[0] = |ok;
    else   on = ok;
    return pol ? on : ~on;
  endfunction

  function automatic logic [2*N-1:0] exp_leds(logic man, logic sus, logic [2:0] cnt,
                                              logic [N-1:0] en, logic [N-1:0] er,
                                              logic [N-1:0] flg, logic [2*N-1:0] sel);
    logic [N-1:0] g, a;
    g = '0; a = '0;
    for (int i = 0; i < N; i++) begin
      if (!sus && i < cnt) begin
        if (man) begin
          g[i] = (sel[2*i +: 2] == 2'd1);
          a[i] = 1'b0;
        end else if (er[i] || flg[i]) a[i] = 1'b1;
        else g[i] = en[i];
      end
    end
    return {g, a};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [2*N-1:0] s;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    gang_mode = 1'b0; en_active_high = 1'b1; suspend = 1'b0; led_manual = 1'b0;
    port_count = 3'd4; pwr_req = '1; port_enabled = '1; port_error = '0;
    led_sel = '0; oc_n = '1; oc_clr = '0;
    tick(3);
    // R10: reset state
    chk("R10 pins", pwr_en_pin, 4'h0);
    chk("R10 flags", oc_change, 4'h0);
    chk("R10 lamps", {led_green, led_amber}, 8'h00);
    rst_n = 1'b1;
    tick(2);
    chk("R1 all on after reset", pwr_en_pin, 4'hf);
    chk("R6 auto green", {led_green, led_amber}, 8'hf0);

    // random static configurations: R1 R2 R3 R6 R7 R8 R9
    for (int it = 0; it < 60; it++) begin
      gang_mode = 1'($urandom);
      en_active_high = 1'($urandom);
      port_count = 3'($urandom_range(0, 4));
      suspend = ($urandom_range(0, 4) == 0);
      led_manual = 1'($urandom);
      pwr_req = 4'($urandom);
      port_enabled = 4'($urandom);
      port_error = 4'($urandom);
      s = 8'($urandom);
      for (int i = 0; i < N; i++) if (s[2*i +: 2] == 2'd2) s[2*i +: 2] = 2'd3;
      led_sel = s;
      tick(2);
      chk("R1 R2 R3 R9 pins", pwr_en_pin,
          exp_pins(gang_mode, en_active_high, port_count, pwr_req, 4'h0));
      chk("R6 R7 R8 R9 lamps", {led_green, led_amber},
          exp_leds(led_manual, suspend, port_count, port_enabled, port_error, 4'h0, led_sel));
    end

    // individual fault filtering
    gang_mode = 1'b0; en_active_high = 1'b1; port_count = 3'd4; suspend = 1'b0;
    led_manual = 1'b0; pwr_req = '1; port_enabled = '1; port_error = '0;
    tick(2);
    oc_n[1] = 1'b0; tick(DEB - 1); oc_n[1] = 1'b1; tick(6);
    chk("R4 short pulse ignored flag", oc_change, 4'h0);
    chk("R4 short pulse ignored power", pwr_en_pin, 4'hf);
    oc_n[1] = 1'b0; tick(DEB + 2); oc_n[1] = 1'b1; tick(3);
    chk("R5 flag set on port1", oc_change, 4'h2);
    chk("R5 port1 power cut", pwr_en_pin, 4'hd);
    chk("R6 amber on flagged port", {led_green, led_amber}, 8'hd2);
    tick(5);
    chk("R5 flag sticky", oc_change, 4'h2);
    oc_clr = 4'h2; tick(1); oc_clr = '0; tick(1);
    chk("R5 cleared", oc_change, 4'h0);
    chk("R5 power restored", pwr_en_pin, 4'hf);

    // ganged mode
    gang_mode = 1'b1; en_active_high = 1'b0; pwr_req = 4'h8;
    tick(2);
    chk("R3 R2 gang fold active low", pwr_en_pin, 4'hf & ~4'h1);
    oc_n[2] = 1'b0; tick(DEB + 3); oc_n[2] = 1'b1; tick(3);
    chk("R3 other pin ignored in gang", oc_change, 4'h0);
    port_count = 3'd3;
    oc_n[0] = 1'b0; tick(DEB + 3); oc_n[0] = 1'b1; tick(3);
    chk("R5 gang fault flags valid ports", oc_change, 4'h7);
    chk("R3 R9 gang pin off", pwr_en_pin, 4'hf);
    oc_clr = 4'h7; tick(1); oc_clr = '0; tick(1);
    chk("R5 gang clear", oc_change, 4'h0);
    chk("R9 port3 request beyond count", pwr_en_pin, 4'hf);
    pwr_req = 4'h2; tick(2);
    chk("R3 gang on from port1 request", pwr_en_pin, 4'he);

    // manual amber blink
    gang_mode = 1'b0; en_active_high = 1'b1; port_count = 3'd4; led_manual = 1'b1;
    led_sel = 8'h02;
    begin
      int seen_on = 0, seen_off = 0, g_on = 0;
      for (int k = 0; k < 4 * HALF; k++) begin
        tick(1);
        if (led_amber[0]) seen_on++; else seen_off++;
        if (led_green[0]) g_on++;
      end
      chk("R7 amber blink lit", 32'(seen_on > 0), 32'd1);
      chk("R7 amber blink dark", 32'(seen_off > 0), 32'd1);
      chk("R7 green dark during amber", 32'(g_on), 32'd0);
    end
    suspend = 1'b1; tick(2);
    chk("R8 suspend dark manual", {led_green, led_amber}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule